// File: doc/BRIEF.md
# Shared-Memory Ring Buffer Accessor

This block moves single bytes into and out of a circular buffer that sits in the memory of another processor. It reaches that memory over an external bus that it must borrow. Each operation begins by asking a bus controller for ownership and waiting for the grant. It then makes its memory reads and writes through a simple request/acknowledge port and gives the bus back. The control indices of the buffer live in that shared memory, and the other processor updates them too, so every remote index is read again inside the tenure that needs it.

The block keeps a local copy of the buffer descriptor: the base address, the size mask, the producer index and the consumer index. Five commands are supported: load the descriptor from a base address, pop a byte, push a byte, sample the empty and full flags, and flush. A flush drops all pending data by copying the remote producer index into the remote consumer slot. A pop that finds the buffer empty, or a push that finds it full, gives the bus back and tries again until it can go on. Every command finishes with a one-cycle `done` pulse, and that pulse comes only after the grant has dropped.

Top module: `rbuf_accessor`

## Requirements
- R1: After reset, `busy`, `done`, `bus_req` and `mem_req` are 0, and `empty` and `full` are both 1.
- R2: Command code 1 (load) with a non-zero `cmd_base` takes the bus and reads the mask at base+0x100, the producer index at base+0x101 and the consumer index at base+0x102. It then gives the bus back and finishes, and later commands use these loaded values.
- R3: `mem_req` is high only while `bus_grant` is high. Once raised, it holds with a stable address, write flag and write data until `mem_ack`.
- R4: Command code 4 (status) reads the remote producer index and the remote consumer index again under bus ownership. It sets `empty` when the remote producer index equals the local consumer index. It sets `full` when ((local producer index + 1) AND mask) equals the remote consumer index.
- R5: While the loaded base is 0, status gives `empty`=1 and `full`=1. Pop returns `rdata`=0, and push, pop and flush finish without raising `bus_req`.
- R6: Command code 2 (pop) on a non-empty buffer returns the byte at base+consumer index on `rdata`. It writes (consumer index + 1) AND mask to base+0x102.
- R7: Command code 3 (push) on a non-full buffer writes `cmd_wdata` at base+producer index. It writes (producer index + 1) AND mask to base+0x101.
- R8: A pop on an empty buffer gives the bus back and takes it again until the remote producer index moves. It finishes only after it has read the new byte.
- R9: A push on a full buffer gives the bus back and takes it again until the remote consumer index moves. It finishes only after it has written the byte.
- R10: Command code 5 (flush) writes the remote producer index into base+0x102, after which status reports `empty`=1.
- R11: `done` is a one-cycle pulse, given only with `bus_req` and `bus_grant` low. Commands presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 3 | 1 load, 2 pop, 3 push, 4 status, 5 flush |
| cmd_base | input | 20 | Base address for the load command |
| cmd_wdata | input | 8 | Byte for the push command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last pop |
| empty | output | 1 | Empty flag from the last status |
| full | output | 1 | Full flag from the last status |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 20 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory access completion |
| mem_rdata | input | 8 | Memory read data |

## Verification
The hardest situations to reach are the waiting pop and the waiting push. They end only when the other processor moves an index in shared memory, and it may do so only while this block holds no bus. The bench plays that processor. It waits a few dozen cycles into a blocked pop or push, then at a cycle where both `bus_req` and `bus_grant` are low it writes the new byte and producer index, or advances the consumer index. It then checks that the command finished only after that write and needed more than one tenure. The random grant and acknowledge delays spread these tenure gaps over different cycle positions.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_POP   = 3'd2,
    OP_PUSH  = 3'd3,
    OP_STAT  = 3'd4,
    OP_FLUSH = 3'd5
  } rb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRAB,
    ST_ACC,
    ST_DROP,
    ST_DONE
  } rb_state_e;
endpackage

// File: rtl/rbuf_rst_sync.sv
module rbuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rbuf_desc.sv
module rbuf_desc #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_base,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              we_mask,
  input  logic              we_in,
  input  logic              we_out,
  input  logic [DATA_W-1:0] idx_val,
  output logic [ADDR_W-1:0] base,
  output logic [DATA_W-1:0] idx_in,
  output logic [DATA_W-1:0] idx_out,
  output logic [DATA_W-1:0] in_nxt,
  output logic [DATA_W-1:0] out_nxt
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [DATA_W-1:0] mask_q, mask_d, in_q, in_d, out_q, out_d;

  always_comb begin
    base_d = base_q;
    mask_d = mask_q;
    in_d   = in_q;
    out_d  = out_q;
    if (we_base) base_d = base_val;
    if (we_mask) mask_d = idx_val;
    if (we_in)   in_d   = idx_val;
    if (we_out)  out_d  = idx_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      in_q   <= '0;
      out_q  <= '0;
    end else begin
      base_q <= base_d;
      mask_q <= mask_d;
      in_q   <= in_d;
      out_q  <= out_d;
    end
  end

  assign base    = base_q;
  assign idx_in  = in_q;
  assign idx_out = out_q;
  assign in_nxt  = (in_q + ONE) & mask_q;
  assign out_nxt = (out_q + ONE) & mask_q;
endmodule

// File: rtl/rbuf_seq.sv
module rbuf_seq
  import rbuf_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int OFS_MASK = 256,
  parameter int OFS_IN   = 257,
  parameter int OFS_OUT  = 258
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] d_base,
  input  logic [DATA_W-1:0] d_in,
  input  logic [DATA_W-1:0] d_out,
  input  logic [DATA_W-1:0] d_in_nxt,
  input  logic [DATA_W-1:0] d_out_nxt,
  output logic              we_base,
  output logic              we_mask,
  output logic              we_in,
  output logic              we_out,
  output logic [DATA_W-1:0] idx_val
);
  localparam int PAD = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);

  rb_state_e         state_q, state_d;
  rb_op_e            op_q, op_d, cmd_op_e;
  logic [1:0]        step_q, step_d;
  logic [DATA_W-1:0] wd_q, wd_d, tmp_q, tmp_d, rd_q, rd_d;
  logic              retry_q, retry_d, empty_q, empty_d, full_q, full_d;
  logic              cmd_known, base_ok;

  assign cmd_op_e  = rb_op_e'(cmd_op);
  assign cmd_known = (cmd_op >= 3'd1) && (cmd_op <= 3'd5);
  assign base_ok   = (d_base != '0);

  // next-state logic
  always_comb begin
    state_d = state_q;  op_d  = op_q;   step_d  = step_q;
    wd_d    = wd_q;     tmp_d = tmp_q;  retry_d = retry_q;
    rd_d    = rd_q;     empty_d = empty_q; full_d = full_q;
    we_base = 1'b0; we_mask = 1'b0; we_in = 1'b0; we_out = 1'b0;
    bus_req = 1'b0; mem_req = 1'b0;
    case (state_q)
      ST_IDLE: if (cmd_valid && cmd_known) begin
        op_d = cmd_op_e; wd_d = cmd_wdata; step_d = '0; retry_d = 1'b0;
        if (cmd_op_e == OP_LOAD) begin
          we_base = 1'b1;
          state_d = (cmd_base != '0) ? ST_GRAB : ST_DONE;
        end else if (!base_ok) begin
          state_d = ST_DONE;
          if (cmd_op_e == OP_POP) rd_d = '0;
          if (cmd_op_e == OP_STAT) begin empty_d = 1'b1; full_d = 1'b1; end
        end else begin
          state_d = ST_GRAB;
        end
      end
      ST_GRAB: begin
        bus_req = 1'b1;
        if (bus_grant) state_d = ST_ACC;
      end
      ST_ACC: begin
        bus_req = 1'b1;
        mem_req = 1'b1;
        if (mem_ack) begin
          step_d = step_q + 2'd1;
          case (op_q)
            OP_LOAD: begin
              if (step_q == 2'd0)      we_mask = 1'b1;
              else if (step_q == 2'd1) we_in   = 1'b1;
              else begin we_out = 1'b1; state_d = ST_DROP; end
            end
            OP_STAT: begin
              if (step_q == 2'd0) empty_d = (mem_rdata == d_out);
              else begin full_d = (d_in_nxt == mem_rdata); state_d = ST_DROP; end
            end
            OP_POP: begin
              if (step_q == 2'd0) begin
                if (mem_rdata == d_out) begin retry_d = 1'b1; state_d = ST_DROP; end
              end else if (step_q == 2'd1) rd_d = mem_rdata;
              else begin we_out = 1'b1; state_d = ST_DROP; end
            end
            OP_PUSH: begin
              if (step_q == 2'd0) begin
                if (d_in_nxt == mem_rdata) begin retry_d = 1'b1; state_d = ST_DROP; end
              end else if (step_q == 2'd2) begin we_in = 1'b1; state_d = ST_DROP; end
            end
            OP_FLUSH: begin
              if (step_q == 2'd0) tmp_d = mem_rdata;
              else begin we_out = 1'b1; state_d = ST_DROP; end
            end
            default: state_d = ST_DROP;
          endcase
        end
      end
      ST_DROP: if (!bus_grant) begin
        if (retry_q) begin
          retry_d = 1'b0; step_d = '0; state_d = ST_GRAB;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // index value fed to the descriptor
  always_comb begin
    case (op_q)
      OP_POP:   idx_val = d_out_nxt;
      OP_PUSH:  idx_val = d_in_nxt;
      OP_FLUSH: idx_val = tmp_q;
      default:  idx_val = mem_rdata;
    endcase
  end

  // access address and data per command step
  always_comb begin
    mem_addr  = d_base + A_IN;
    mem_we    = 1'b0;
    mem_wdata = wd_q;
    case (op_q)
      OP_LOAD:
        if (step_q == 2'd0)      mem_addr = d_base + A_MASK;
        else if (step_q == 2'd2) mem_addr = d_base + A_OUT;
      OP_STAT:
        if (step_q != 2'd0) mem_addr = d_base + A_OUT;
      OP_POP:
        if (step_q == 2'd1) mem_addr = d_base + {{PAD{1'b0}}, d_out};
        else if (step_q == 2'd2) begin
          mem_addr = d_base + A_OUT; mem_we = 1'b1; mem_wdata = d_out_nxt;
        end
      OP_PUSH:
        if (step_q == 2'd0) mem_addr = d_base + A_OUT;
        else if (step_q == 2'd1) begin
          mem_addr = d_base + {{PAD{1'b0}}, d_in}; mem_we = 1'b1;
        end else begin
          mem_we = 1'b1; mem_wdata = d_in_nxt;
        end
      OP_FLUSH:
        if (step_q != 2'd0) begin
          mem_addr = d_base + A_OUT; mem_we = 1'b1; mem_wdata = tmp_q;
        end
      default: mem_addr = d_base + A_IN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; op_q <= OP_NOP; step_q <= '0;
      wd_q <= '0; tmp_q <= '0; rd_q <= '0; retry_q <= 1'b0;
      empty_q <= 1'b1; full_q <= 1'b1;
    end else begin
      state_q <= state_d; op_q <= op_d; step_q <= step_d;
      wd_q <= wd_d; tmp_q <= tmp_d; rd_q <= rd_d; retry_q <= retry_d;
      empty_q <= empty_d; full_q <= full_d;
    end
  end

  assign busy  = (state_q != ST_IDLE);
  assign done  = (state_q == ST_DONE);
  assign rdata = rd_q;
  assign empty = empty_q;
  assign full  = full_q;

  // R3: memory traffic only under bus ownership
  p_mem_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> bus_grant);
  // R3: request held steady until acknowledged
  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  // R5: no bus traffic without a configured base
  p_base0_nobus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (d_base == '0) |-> !bus_req);
  // R11: completion only after the bus is handed back
  p_done_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_grant && !bus_req));
  // R11: single-cycle completion pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/rbuf_accessor.sv
module rbuf_accessor #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int OFS_MASK = 256,
  parameter int OFS_IN   = 257,
  parameter int OFS_OUT  = 258
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              rst_s_n;
  logic              we_base, we_mask, we_in, we_out;
  logic [DATA_W-1:0] idx_val, d_in, d_out, d_in_nxt, d_out_nxt;
  logic [ADDR_W-1:0] d_base;

  rbuf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  rbuf_desc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_desc (
    .clk(clk), .rst_n(rst_s_n),
    .we_base(we_base), .base_val(cmd_base), .we_mask(we_mask),
    .we_in(we_in), .we_out(we_out), .idx_val(idx_val),
    .base(d_base), .idx_in(d_in), .idx_out(d_out),
    .in_nxt(d_in_nxt), .out_nxt(d_out_nxt)
  );

  rbuf_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_MASK(OFS_MASK), .OFS_IN(OFS_IN), .OFS_OUT(OFS_OUT)
  ) u_seq (
    .clk(clk), .rst_n(rst_s_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_base(cmd_base),
    .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rdata(rdata), .empty(empty), .full(full),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .d_base(d_base), .d_in(d_in), .d_out(d_out),
    .d_in_nxt(d_in_nxt), .d_out_nxt(d_out_nxt),
    .we_base(we_base), .we_mask(we_mask), .we_in(we_in), .we_out(we_out),
    .idx_val(idx_val)
  );
endmodule

// File: tb/rbuf_accessor_tb.sv
`timescale 1ns/1ps
module rbuf_accessor_tb;
  localparam logic [19:0] BASE = 20'h00400;
  localparam int RB = 12'h400;
  localparam int RM = 12'h500;
  localparam int RI = 12'h501;
  localparam int RO = 12'h502;
  localparam logic [7:0] MSK = 8'h0F;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [2:0] cmd_op;
  logic [19:0] cmd_base;
  logic [7:0] cmd_wdata;
  logic busy, done, empty, full, bus_req, mem_req, mem_we;
  logic [7:0] rdata, mem_wdata, mem_rdata;
  logic [19:0] mem_addr;
  logic bus_grant, mem_ack;

  logic [7:0] mem [0:4095];
  logic [7:0] q [$];
  logic [7:0] m_in, m_out;
  int nchk = 0, nfail = 0, grabs = 0;
  logic breq_d, done_d;

  always #2 clk = ~clk;

  rbuf_accessor u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_base(cmd_base), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rdata(rdata), .empty(empty), .full(full), .bus_req(bus_req),
    .bus_grant(bus_grant), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[11:0]];

  // bus controller and memory model with random latency
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_grant <= 1'b0; mem_ack <= 1'b0; breq_d <= 1'b0;
    end else begin
      breq_d <= bus_req;
      if (bus_req && !breq_d) grabs <= grabs + 1;
      if (!bus_req) bus_grant <= 1'b0;
      else if (($urandom % 2) == 0) bus_grant <= 1'b1;
      mem_ack <= mem_req && !mem_ack && (($urandom % 3) != 0);
      if (mem_req && mem_ack && mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R11: done pulse width and bus state at completion
  always @(negedge clk) begin
    done_d <= done;
    if (rst_n && done) begin
      chk("R11 done with bus released", {bus_req, bus_grant}, 0);
      chk("R11 done single cycle", done_d, 0);
    end
  end

  task automatic cmd(input logic [2:0] op, input logic [19:0] b, input logic [7:0] d);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_base = b; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (!done) chk("command timeout", 0, 1);
  endtask

  task automatic do_push(input logic [7:0] d);
    logic [7:0] old_in;
    old_in = m_in;
    cmd(3'd3, '0, d);
    q.push_back(d);
    m_in = (m_in + 8'd1) & MSK;
    chk("R7 data byte at base+in", mem[RB + int'(old_in)], d);
    chk("R7 remote producer index", mem[RI], m_in);
  endtask

  task automatic do_pop();
    logic [7:0] e;
    e = q.pop_front();
    cmd(3'd2, '0, 8'h00);
    m_out = (m_out + 8'd1) & MSK;
    chk("R6 popped byte", rdata, e);
    chk("R6 remote consumer index", mem[RO], m_out);
  endtask

  task automatic do_stat();
    cmd(3'd4, '0, 8'h00);
    chk("R4 empty flag", empty, (q.size() == 0));
    chk("R4 full flag", full, (q.size() == 15));
  endtask

  task automatic wait_gap();
    while (bus_req || bus_grant) @(negedge clk);
  endtask

  initial begin
    int g;
    logic flag;
    logic [7:0] old_in;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_base = '0; cmd_wdata = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 empty/full", {empty, full}, 2'b11);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 descriptor load
    mem[RM] = MSK; mem[RI] = 8'h05; mem[RO] = 8'h05;
    m_in = 8'h05; m_out = 8'h05;
    g = grabs;
    cmd(3'd1, BASE, 8'h00);
    chk("R2 single tenure for load", grabs - g, 1);
    do_stat();
    chk("R2 loaded indices give empty", empty, 1);

    // R6 R7 R4 random traffic
    for (int k = 0; k < 60; k++) begin
      if (q.size() < 15 && (q.size() == 0 || ($urandom % 2) == 0)) do_push(8'($urandom));
      else do_pop();
      if (k % 5 == 4) do_stat();
    end

    // fill to full, then R9 blocked push
    while (q.size() < 15) do_push(8'($urandom));
    do_stat();
    chk("R4 full at capacity", full, 1);
    g = grabs; flag = 1'b0; old_in = m_in;
    fork
      begin
        cmd(3'd3, '0, 8'hA5);
        chk("R9 push finished only after space appeared", flag, 1);
      end
      begin
        repeat (40) @(negedge clk);
        wait_gap();
        void'(q.pop_front());
        m_out = (m_out + 8'd1) & MSK;
        mem[RO] = m_out;
        flag = 1'b1;
      end
    join
    q.push_back(8'hA5);
    m_in = (m_in + 8'd1) & MSK;
    chk("R9 retried over several tenures", (grabs - g) > 1, 1);
    chk("R9 byte written", mem[RB + int'(old_in)], 8'hA5);
    chk("R9 producer index", mem[RI], m_in);
    cmd(3'd1, BASE, 8'h00);

    // drain, then R8 blocked pop
    while (q.size() > 0) do_pop();
    g = grabs; flag = 1'b0;
    fork
      begin
        cmd(3'd2, '0, 8'h00);
        chk("R8 pop finished only after data appeared", flag, 1);
      end
      begin
        repeat (40) @(negedge clk);
        wait_gap();
        mem[RB + int'(m_in)] = 8'h3C;
        m_in = (m_in + 8'd1) & MSK;
        mem[RI] = m_in;
        flag = 1'b1;
      end
    join
    m_out = (m_out + 8'd1) & MSK;
    chk("R8 popped byte", rdata, 8'h3C);
    chk("R8 retried over several tenures", (grabs - g) > 1, 1);
    chk("R8 consumer index", mem[RO], m_out);
    cmd(3'd1, BASE, 8'h00);

    // R11 command ignored while busy
    do_push(8'h11);
    fork
      do_pop();
      begin
        repeat (2) @(negedge clk);
        for (int j = 0; j < 3; j++) begin
          cmd_valid = 1'b1; cmd_op = 3'd3; cmd_wdata = 8'h99;
          @(negedge clk);
        end
        cmd_valid = 1'b0;
      end
    join
    repeat (10) @(negedge clk);
    chk("R11 ignored push left producer index", mem[RI], m_in);
    chk("R11 ignored push left busy low", busy, 0);
    do_stat();

    // R10 flush
    for (int j = 0; j < 3; j++) do_push(8'($urandom));
    cmd(3'd5, '0, 8'h00);
    chk("R10 consumer slot equals producer", mem[RO], m_in);
    q.delete(); m_out = m_in;
    cmd(3'd4, '0, 8'h00);
    chk("R10 empty after flush", empty, 1);

    // R5 no base configured
    cmd(3'd1, 20'h0, 8'h00);
    g = grabs;
    cmd(3'd4, '0, 8'h00);
    chk("R5 status flags without base", {empty, full}, 2'b11);
    cmd(3'd3, '0, 8'h77);
    cmd(3'd2, '0, 8'h00);
    chk("R5 pop returns zero", rdata, 0);
    cmd(3'd5, '0, 8'h00);
    chk("R5 no bus request", grabs - g, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule